// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers single-cycle event pulses from a set of sources, plus one external level-sensitive interrupt line, into a sticky status register. Software reads the status register over a simple register port and clears any bit by writing a one to it. A bit written with zero stays as it was. A per-bit enable mask selects which latched sources may interrupt. A separate global enable bit gates the one combined interrupt output.

Besides the combined interrupt, the block gives the index of the lowest-numbered source that is both latched and enabled in the mask, with a valid flag. A handler can use this index to service sources in a fixed priority order. The status has 27 bits, indices 0 to 26. Bits 0..15 form the descriptor-event group, and software can mask that group as a whole. Bit 25 follows the external level line, and bit 26 records bus-abort events.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status, mask and global enable registers are all zero. The interrupt output is low and the index valid flag is low.
- R2: An event pulse on input bit i sets status bit i on the next clock edge. The bit stays set until it is cleared.
- R3: A write to the status register (address 0) clears each status bit whose write-data bit is 1. It leaves each bit whose write-data bit is 0 unchanged.
- R4: If an event on a bit and a clearing write to that bit occur in the same cycle, the bit stays set.
- R5: Status bit 25 is set every cycle while the external level input is high. It therefore reappears after a clear while the level stays high.
- R6: The pending vector is status AND mask, where a mask bit of 1 enables that source. The mask register is at address 1 and reads back what was written. Writing the low 16 mask bits as zero masks the descriptor group (bits 0..15) as a set.
- R7: The interrupt output is a register. It is high in the cycle after any pending bit is set while bit 0 of the global enable register (address 2) is 1. When that bit is 0, the output stays low.
- R8: The index output gives the lowest-numbered pending bit, and the index valid flag is high exactly when any bit is pending. When nothing is pending the index is zero. The global enable does not affect the index or the valid flag.
- R9: Reads are combinational. Address 0 returns status, address 1 returns mask and address 2 returns the global enable in bit 0. Any other address returns zero, and a write to another address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventIn | input | 27 | Event pulses, one per status bit |
| extLevel | input | 1 | External level interrupt feeding bit 25 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 27 | Write data |
| regRdData | output | 27 | Read data |
| irqOut | output | 1 | Registered combined interrupt |
| srcIdx | output | 5 | Lowest pending source index |
| srcIdxValid | output | 1 | High when any source is pending |

## Verification
Each of the 27 bits is set on its own by a single event, then cleared. This walk separates the bit positions and shows that the priority encoder reports each index. Pairs of bits are set with every mask value that separates them, which shows that the lowest enabled bit wins over higher ones and over masked lower ones. Clear-with-zero writes, collisions between an event and a clear on the same bit, and writes to the unused address show that nothing changes except what the requirements name. The level input is held high across a clear to show that bit 25 reasserts, and the global enable is toggled to show that it gates only the output.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NumSrc = 27;
  localparam int IdxW = $clog2(NumSrc);
  localparam int ExtBit = 25;

  typedef enum logic [1:0] {
    AddrStatus = 2'd0,
    AddrMask   = 2'd1,
    AddrEnable = 2'd2,
    AddrNone   = 2'd3
  } regAddrE;

  typedef struct packed {
    logic clrStatus;
    logic wrMask;
    logic wrEnable;
  } ctrlStrobesT;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  output ctrlStrobesT strobes
);
  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      unique case (regAddrE'(regAddr))
        AddrStatus: strobes.clrStatus = 1'b1;
        AddrMask:   strobes.wrMask    = 1'b1;
        AddrEnable: strobes.wrEnable  = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int Width = NumSrc,
  parameter int ExtPos = ExtBit,
  localparam int IW = $clog2(Width)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] eventIn,
  input  logic             extLevel,
  input  ctrlStrobesT      strobes,
  input  logic [Width-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [Width-1:0] rdData,
  output logic             irqOut,
  output logic [IW-1:0]    srcIdx,
  output logic             srcIdxValid
);
  logic [Width-1:0] statusQ, maskQ, setVec, pending;
  logic enableQ;

  always_comb begin
    setVec = eventIn;
    setVec[ExtPos] = eventIn[ExtPos] | extLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      enableQ <= 1'b0;
      irqOut  <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~(strobes.clrStatus ? wrData : '0)) | setVec;
      if (strobes.wrMask) maskQ <= wrData;
      if (strobes.wrEnable) enableQ <= wrData[0];
      irqOut <= enableQ & (|pending);
    end
  end

  assign pending = statusQ & maskQ;

  always_comb begin
    srcIdx = '0;
    for (int i = Width - 1; i >= 0; i--) begin
      if (pending[i]) srcIdx = IW'(i);
    end
  end
  assign srcIdxValid = |pending;

  always_comb begin
    unique case (regAddrE'(rdAddr))
      AddrStatus: rdData = statusQ;
      AddrMask:   rdData = maskQ;
      AddrEnable: rdData = {{(Width-1){1'b0}}, enableQ};
      default:    rdData = '0;
    endcase
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    eventIn[0] |=> statusQ[0]);
  assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrStatus && eventIn[1]) |=> statusQ[1]);
  assert_level_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    extLevel |=> statusQ[ExtPos]);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |=> !irqOut);
  assert_valid_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    srcIdxValid |-> (pending[srcIdx] && ((pending & ((Width'(1) << srcIdx) - Width'(1))) == '0)));
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[2] && !(strobes.clrStatus && wrData[2])) |=> statusQ[2]);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] eventIn,
  input  logic              extLevel,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [NumSrc-1:0] regWrData,
  output logic [NumSrc-1:0] regRdData,
  output logic              irqOut,
  output logic [IdxW-1:0]   srcIdx,
  output logic              srcIdxValid
);
  ctrlStrobesT strobes;

  irq_agg_ctrl i_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strobes(strobes)
  );

  irq_agg_datapath #(.Width(NumSrc), .ExtPos(ExtBit)) i_dp (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .extLevel(extLevel),
    .strobes(strobes), .wrData(regWrData), .rdAddr(regAddr),
    .rdData(regRdData), .irqOut(irqOut), .srcIdx(srcIdx),
    .srcIdxValid(srcIdxValid)
  );
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int ClkPeriod = 10;
  localparam int N = 27;

  logic clk = 1'b0, rstN = 1'b0, extLevel = 1'b0, regWrEn = 1'b0;
  logic [N-1:0] eventIn = '0, regWrData = '0, regRdData;
  logic [1:0] regAddr = 2'd0;
  logic irqOut, srcIdxValid;
  logic [4:0] srcIdx;
  int checks = 0, fails = 0;
  bit done = 0;

  irq_aggregator i_irq_aggregator (.*);

  always #(ClkPeriod/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    regWrEn = 1; regAddr = a; regWrData = d; tick();
    regWrEn = 0; regWrData = '0;
  endtask

  function automatic int lowIdx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic readStatus(output logic [N-1:0] v);
    regAddr = 2'd0; #1; v = regRdData;
  endtask

  initial begin
    #(ClkPeriod*150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    tick(); tick(); rstN = 1; #1;
    regAddr = 0; #1; chk("R1 status", regRdData, 0);
    regAddr = 1; #1; chk("R1 mask", regRdData, 0);
    regAddr = 2; #1; chk("R1 enable", regRdData, 0);
    chk("R1 irq", irqOut, 0); chk("R1 valid", srcIdxValid, 0);

    wr(2'd1, '1);
    regAddr = 1; #1; chk("R6 mask readback", regRdData, {N{1'b1}});
    // R2/R8 walk
    for (int i = 0; i < N; i++) begin
      eventIn = N'(1) << i; tick(); eventIn = '0;
      readStatus(v); chk("R2 set bit", v, N'(1) << i);
      tick(); readStatus(v); chk("R2 sticky", v, N'(1) << i);
      chk("R8 idx", srcIdx, i); chk("R8 valid", srcIdxValid, 1);
      chk("R7 disabled irq", irqOut, 0);
      wr(2'd0, N'(1) << i);
      readStatus(v); chk("R3 cleared", v, 0);
      chk("R8 none valid", srcIdxValid, 0); chk("R8 none idx", srcIdx, 0);
    end
    // R8/R6 pairs with masks
    for (int a = 0; a < N; a += 3) begin
      for (int b = a + 1; b < N; b += 4) begin
        for (int m = 0; m < 4; m++) begin
          logic [N-1:0] mk, pv;
          mk = '0; mk[a] = m[0]; mk[b] = m[1];
          wr(2'd1, mk);
          eventIn = (N'(1) << a) | (N'(1) << b); tick(); eventIn = '0;
          pv = ((N'(1) << a) | (N'(1) << b)) & mk;
          chk("R6 pending valid", srcIdxValid, |pv);
          chk("R8 lowest", srcIdx, (|pv) ? lowIdx(pv) : 0);
          wr(2'd0, '1);
        end
      end
    end
    // R3 write zero keeps
    eventIn = 27'h5; tick(); eventIn = '0;
    wr(2'd0, 27'h0); readStatus(v); chk("R3 zero write keeps", v, 27'h5);
    wr(2'd0, 27'h1); readStatus(v); chk("R3 partial clear", v, 27'h4);
    // R4 collision
    regWrEn = 1; regAddr = 0; regWrData = 27'h4; eventIn = 27'h4; tick();
    regWrEn = 0; eventIn = 0; readStatus(v); chk("R4 event wins", v, 27'h4);
    wr(2'd0, '1);
    // R9 unused address
    wr(2'd3, '1);
    regAddr = 3; #1; chk("R9 addr3 reads zero", regRdData, 0);
    readStatus(v); chk("R9 status untouched", v, 0);
    regAddr = 2; #1; chk("R9 enable untouched", regRdData, 0);
    // R6 group mask of descriptor bits
    wr(2'd1, 27'h6000000 | 27'h0);
    eventIn = 27'h3; tick(); eventIn = 0; tick();
    chk("R6 group masked", srcIdxValid, 0);
    // R7 enable gating
    wr(2'd1, '1); wr(2'd2, 27'h1);
    tick(); chk("R7 irq enabled", irqOut, 1);
    wr(2'd2, 27'h0); tick(); chk("R7 irq disabled", irqOut, 0);
    chk("R8 valid ignores enable", srcIdxValid, 1);
    wr(2'd0, '1); wr(2'd2, 27'h1); tick();
    chk("R7 irq low no pending", irqOut, 0);
    // R5 level
    extLevel = 1; tick(); readStatus(v); chk("R5 level sets", v, N'(1) << 25);
    wr(2'd0, N'(1) << 25); readStatus(v); chk("R5 reasserts", v, N'(1) << 25);
    chk("R8 idx ext", srcIdx, 25);
    extLevel = 0; wr(2'd0, N'(1) << 25); readStatus(v); chk("R5 clears when low", v, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule